// File: doc/BRIEF.md
# Bus Cycle Type Decoder

This block watches the status lines of a 32-bit processor local bus without ever driving them. It samples on the fast bus clock. A cycle is taken into account only on an edge where the address strobe is asserted (low) and the processor's internal clock phase input is high. On such an edge the block reads three status bits: memory versus I/O, data versus code, and write versus read. It also reads the four active-low byte enables and address bits 31:2. From these it names the kind of bus cycle that has started.

The result is a registered one-hot cycle-type vector and a one-period valid strobe. A lock-permission flag reports whether the decoded cycle is one that may run as a locked transfer. An error strobe flags status combinations that no legal cycle produces. The halt and shutdown special cycles share one status code. The block tells them apart by the byte-enable pattern and by whether the upper address bits are all zero. Downstream logic such as wait-state generators, lock checkers and trace units can use these outputs in place of decoding the raw status lines themselves.

Top module: `cycle_decoder`

## Requirements
- R1: Status is captured only on a rising `clk` edge where `adsN` is 0 and `phaseHi` is 1. On any other edge the status, byte-enable and address inputs have no effect on any output.
- R2: With status {memIoN,dataCodeN,writeReadN} = 000 the type is interrupt acknowledge (`cycleType` bit 0). 010 gives I/O read (bit 1) and 011 gives I/O write (bit 2).
- R3: Status 100 gives code fetch (bit 3), 110 gives memory data read (bit 4) and 111 gives memory data write (bit 5).
- R4: Status 101 with `byteEnN` = 1011 and `addrHi` all zero gives halt (bit 6). Status 101 with `byteEnN` = 1110 and `addrHi` all zero gives shutdown (bit 7).
- R5: Status 001, or status 101 with any other byte-enable or address pattern, raises `encodingErr` for exactly one period. It also clears `cycleType` and `lockable`, and `cycleValid` stays 0.
- R6: `lockable` is 1 after an interrupt acknowledge, a memory data read or a memory data write. It is 0 after I/O, code fetch, halt and shutdown cycles.
- R7: Outputs change one edge after a qualified sample. `cycleValid` is high for one period only. `cycleType` and `lockable` hold their value until the next qualified sample.
- R8: A synchronous active-high `rst` clears all outputs to 0 at the next edge.
- R9: `cycleType` has at most one bit set. It has exactly one bit set whenever `cycleValid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock (double-rate processor clock) |
| rst | input | 1 | Synchronous reset, active high |
| phaseHi | input | 1 | Internal clock phase, 1 in the phase where status is sampled |
| adsN | input | 1 | Address strobe, active low |
| memIoN | input | 1 | 1 = memory, 0 = I/O |
| dataCodeN | input | 1 | 1 = data, 0 = code/control |
| writeReadN | input | 1 | 1 = write, 0 = read |
| byteEnN | input | 4 | Byte enables, active low |
| addrHi | input | 30 | Address bits 31:2 |
| cycleType | output | 8 | One-hot cycle kind (bit positions as in R2–R4) |
| cycleValid | output | 1 | One-period strobe for a newly decoded legal cycle |
| lockable | output | 1 | Decoded cycle may be locked |
| encodingErr | output | 1 | One-period strobe for an illegal encoding |

## Verification
Every result is due one edge after the qualified sample. That edge sets `cycleType`, `lockable`, `cycleValid` or `encodingErr`. The next edge without a qualified sample clears the two strobes and leaves the type and lock flag untouched. The bench drives inputs on falling edges. It checks on the falling edge after the sampling edge, then checks again one period later to confirm that the strobes have dropped and the held values remain. The ignore checks first place a known type in the outputs. They then present a different status with a disqualified strobe or phase and check that the known type is still there one period later.

// File: rtl/cyc_pkg.sv
package cyc_pkg;
  typedef enum logic [2:0] {
    KIND_INTA  = 3'd0,
    KIND_IORD  = 3'd1,
    KIND_IOWR  = 3'd2,
    KIND_CODE  = 3'd3,
    KIND_MRD   = 3'd4,
    KIND_MWR   = 3'd5,
    KIND_HALT  = 3'd6,
    KIND_SHUT  = 3'd7
  } cycKindE;

  localparam int NUM_KINDS = 8;

  // status code = {memIoN, dataCodeN, writeReadN}
  localparam logic [2:0] ST_INTA    = 3'b000;
  localparam logic [2:0] ST_ILLEGAL = 3'b001;
  localparam logic [2:0] ST_IORD    = 3'b010;
  localparam logic [2:0] ST_IOWR    = 3'b011;
  localparam logic [2:0] ST_CODE    = 3'b100;
  localparam logic [2:0] ST_SPECIAL = 3'b101;
  localparam logic [2:0] ST_MRD     = 3'b110;
  localparam logic [2:0] ST_MWR     = 3'b111;

  typedef struct packed {
    logic capture;
    logic markValid;
    logic markErr;
  } ctlStrobesT;

  function automatic logic kindLockable(cycKindE k);
    return (k == KIND_INTA) || (k == KIND_MRD) || (k == KIND_MWR);
  endfunction
endpackage

// File: rtl/cyc_control.sv
module cyc_control
  import cyc_pkg::*;
(
  input  logic       adsN,
  input  logic       phaseHi,
  input  logic       legal,
  output ctlStrobesT strobes
);
  logic qualified;

  always_comb begin
    qualified         = !adsN && phaseHi;
    strobes.capture   = qualified;
    strobes.markValid = qualified && legal;
    strobes.markErr   = qualified && !legal;
  end
endmodule

// File: rtl/cyc_datapath.sv
module cyc_datapath
  import cyc_pkg::*;
#(
  parameter int ADDR_HI_W = 30,
  parameter int BE_W      = 4,
  parameter int HALT_LANE = 2,
  parameter int SHUT_LANE = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  ctlStrobesT           strobes,
  input  logic                 memIoN,
  input  logic                 dataCodeN,
  input  logic                 writeReadN,
  input  logic [BE_W-1:0]      byteEnN,
  input  logic [ADDR_HI_W-1:0] addrHi,
  output logic                 legal,
  output logic [NUM_KINDS-1:0] cycleType,
  output logic                 cycleValid,
  output logic                 lockable,
  output logic                 encodingErr
);
  localparam logic [BE_W-1:0] HALT_BE = ~(BE_W'(1) << HALT_LANE);
  localparam logic [BE_W-1:0] SHUT_BE = ~(BE_W'(1) << SHUT_LANE);

  logic [2:0]           status;
  logic                 addrZero;
  cycKindE              kind;
  logic [NUM_KINDS-1:0] nextType;
  logic [NUM_KINDS-1:0] typeQ;
  logic                 validQ, errQ, lockQ;

  assign status   = {memIoN, dataCodeN, writeReadN};
  assign addrZero = (addrHi == '0);

  always_comb begin
    kind  = KIND_INTA;
    legal = 1'b1;
    unique case (status)
      ST_INTA:    kind = KIND_INTA;
      ST_IORD:    kind = KIND_IORD;
      ST_IOWR:    kind = KIND_IOWR;
      ST_CODE:    kind = KIND_CODE;
      ST_MRD:     kind = KIND_MRD;
      ST_MWR:     kind = KIND_MWR;
      ST_SPECIAL: begin
        if (addrZero && byteEnN == HALT_BE)      kind = KIND_HALT;
        else if (addrZero && byteEnN == SHUT_BE) kind = KIND_SHUT;
        else                                     legal = 1'b0;
      end
      ST_ILLEGAL: legal = 1'b0;
      default:    legal = 1'b0;
    endcase
  end

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_onehot
    assign nextType[k] = legal && (kind == cycKindE'(k));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      typeQ  <= '0;
      lockQ  <= 1'b0;
      validQ <= 1'b0;
      errQ   <= 1'b0;
    end else begin
      validQ <= strobes.markValid;
      errQ   <= strobes.markErr;
      if (strobes.capture) begin
        typeQ <= nextType;
        lockQ <= legal && kindLockable(kind);
      end
    end
  end

  assign cycleType   = typeQ;
  assign cycleValid  = validQ;
  assign lockable    = lockQ;
  assign encodingErr = errQ;
endmodule

// File: rtl/cycle_decoder.sv
module cycle_decoder
  import cyc_pkg::*;
#(
  parameter int ADDR_HI_W = 30,
  parameter int BE_W      = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 phaseHi,
  input  logic                 adsN,
  input  logic                 memIoN,
  input  logic                 dataCodeN,
  input  logic                 writeReadN,
  input  logic [BE_W-1:0]      byteEnN,
  input  logic [ADDR_HI_W-1:0] addrHi,
  output logic [NUM_KINDS-1:0] cycleType,
  output logic                 cycleValid,
  output logic                 lockable,
  output logic                 encodingErr
);
  ctlStrobesT strobes;
  logic       legal;

  cyc_control u_ctl (
    .adsN    (adsN),
    .phaseHi (phaseHi),
    .legal   (legal),
    .strobes (strobes)
  );

  cyc_datapath #(.ADDR_HI_W(ADDR_HI_W), .BE_W(BE_W)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .strobes     (strobes),
    .memIoN      (memIoN),
    .dataCodeN   (dataCodeN),
    .writeReadN  (writeReadN),
    .byteEnN     (byteEnN),
    .addrHi      (addrHi),
    .legal       (legal),
    .cycleType   (cycleType),
    .cycleValid  (cycleValid),
    .lockable    (lockable),
    .encodingErr (encodingErr)
  );
endmodule

// File: rtl/cycle_decoder_checker.sv
module cycle_decoder_checker
  import cyc_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic                 adsN,
  input logic                 phaseHi,
  input logic [NUM_KINDS-1:0] cycleType,
  input logic                 cycleValid,
  input logic                 lockable,
  input logic                 encodingErr
);
  logic sampleEdge;
  assign sampleEdge = !adsN && phaseHi;

  assert_valid_qualified_R1: assert property (@(posedge clk) disable iff (rst)
    cycleValid |-> $past(sampleEdge));

  assert_err_qualified_R1: assert property (@(posedge clk) disable iff (rst)
    encodingErr |-> $past(sampleEdge));

  assert_err_no_type_R5: assert property (@(posedge clk) disable iff (rst)
    encodingErr |-> (cycleType == '0) && !cycleValid && !lockable);

  assert_lock_kind_R6: assert property (@(posedge clk) disable iff (rst)
    lockable |-> (cycleType[KIND_INTA] || cycleType[KIND_MRD] || cycleType[KIND_MWR]));

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(sampleEdge) |-> ($stable(cycleType) && $stable(lockable) && !cycleValid));

  assert_reset_clear_R8: assert property (@(posedge clk)
    $past(rst) === 1'b1 |-> (cycleType == '0) && !cycleValid && !encodingErr && !lockable);

  assert_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cycleType));

  assert_valid_type_R9: assert property (@(posedge clk) disable iff (rst)
    cycleValid |-> $countones(cycleType) == 1);
endmodule

bind cycle_decoder cycle_decoder_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .adsN        (adsN),
  .phaseHi     (phaseHi),
  .cycleType   (cycleType),
  .cycleValid  (cycleValid),
  .lockable    (lockable),
  .encodingErr (encodingErr)
);

// File: tb/tb_cycle_decoder.sv
`timescale 1ns/1ps
module tb_cycle_decoder;
  logic        clk = 1'b0;
  logic        rst;
  logic        phaseHi;
  logic        adsN;
  logic        memIoN, dataCodeN, writeReadN;
  logic [3:0]  byteEnN;
  logic [29:0] addrHi;
  logic [7:0]  cycleType;
  logic        cycleValid, lockable, encodingErr;

  int checkCount = 0;
  int failCount  = 0;

  always #10 clk = ~clk;

  cycle_decoder dut (
    .clk(clk), .rst(rst), .phaseHi(phaseHi), .adsN(adsN),
    .memIoN(memIoN), .dataCodeN(dataCodeN), .writeReadN(writeReadN),
    .byteEnN(byteEnN), .addrHi(addrHi),
    .cycleType(cycleType), .cycleValid(cycleValid),
    .lockable(lockable), .encodingErr(encodingErr)
  );

  task automatic expectVal(string tag, logic [31:0] act, logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expectAll(string tag, logic [7:0] t, logic v, logic l, logic e);
    expectVal({tag, " type"},  32'(cycleType),   32'(t));
    expectVal({tag, " valid"}, 32'(cycleValid),  32'(v));
    expectVal({tag, " lock"},  32'(lockable),    32'(l));
    expectVal({tag, " err"},   32'(encodingErr), 32'(e));
  endtask

  task automatic setStatus(logic [2:0] st, logic [3:0] be, logic [29:0] a);
    {memIoN, dataCodeN, writeReadN} = st;
    byteEnN = be;
    addrHi  = a;
  endtask

  // one qualified sample, then one idle period
  task automatic runCycle(string tag, logic [2:0] st, logic [3:0] be, logic [29:0] a,
                          logic [7:0] expType, logic expLock, logic expErr);
    @(negedge clk);
    setStatus(st, be, a);
    adsN = 1'b0; phaseHi = 1'b1;
    @(negedge clk);
    adsN = 1'b1; phaseHi = 1'b0;
    setStatus(3'b001, 4'b0000, 30'h3fff_ffff);
    expectAll({tag, " strobe"}, expType, !expErr, expLock, expErr);
    @(negedge clk);
    expectAll({tag, " held R7"}, expType, 1'b0, expLock, 1'b0);
  endtask

  task automatic testReset();
    rst = 1'b1; adsN = 1'b1; phaseHi = 1'b0;
    setStatus(3'b000, 4'hf, '0);
    repeat (2) @(negedge clk);
    expectAll("R8 reset", 8'h00, 1'b0, 1'b0, 1'b0);
    rst = 1'b0;
  endtask

  task automatic testLegalKinds();
    runCycle("R2 inta",   3'b000, 4'b0000, 30'h0000_0001, 8'h01, 1'b1, 1'b0);
    runCycle("R2 iord",   3'b010, 4'b1100, 30'h0000_0123, 8'h02, 1'b0, 1'b0);
    runCycle("R2 iowr",   3'b011, 4'b0111, 30'h0000_0fff, 8'h04, 1'b0, 1'b0);
    runCycle("R3 code",   3'b100, 4'b0000, 30'h1234_5678, 8'h08, 1'b0, 1'b0);
    runCycle("R3 memrd",  3'b110, 4'b1110, 30'h0000_0000, 8'h10, 1'b1, 1'b0);
    runCycle("R6 memwr",  3'b111, 4'b0011, 30'h2aaa_aaaa, 8'h20, 1'b1, 1'b0);
  endtask

  task automatic testSpecial();
    runCycle("R4 halt",     3'b101, 4'b1011, 30'h0, 8'h40, 1'b0, 1'b0);
    runCycle("R4 shutdown", 3'b101, 4'b1110, 30'h0, 8'h80, 1'b0, 1'b0);
    runCycle("R5 halt addr",  3'b101, 4'b1011, 30'h0000_0004, 8'h00, 1'b0, 1'b1);
    runCycle("R5 shut addr",  3'b101, 4'b1110, 30'h2000_0000, 8'h00, 1'b0, 1'b1);
    runCycle("R5 bad be",     3'b101, 4'b1101, 30'h0, 8'h00, 1'b0, 1'b1);
    runCycle("R5 all be",     3'b101, 4'b0000, 30'h0, 8'h00, 1'b0, 1'b1);
    runCycle("R5 code001",    3'b001, 4'b1011, 30'h0, 8'h00, 1'b0, 1'b1);
  endtask

  task automatic testIgnored();
    runCycle("R1 setup", 3'b111, 4'b0000, 30'h10, 8'h20, 1'b1, 1'b0);
    // strobe low, phase low
    @(negedge clk);
    setStatus(3'b010, 4'b0000, 30'h5);
    adsN = 1'b0; phaseHi = 1'b0;
    @(negedge clk);
    expectAll("R1 phase low", 8'h20, 1'b0, 1'b1, 1'b0);
    // phase high, strobe high, illegal status
    setStatus(3'b001, 4'b0000, 30'h5);
    adsN = 1'b1; phaseHi = 1'b1;
    @(negedge clk);
    expectAll("R1 strobe high", 8'h20, 1'b0, 1'b1, 1'b0);
    adsN = 1'b1; phaseHi = 1'b0;
    repeat (3) @(negedge clk);
    expectAll("R7 long hold", 8'h20, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic testBackToBack();
    @(negedge clk);
    setStatus(3'b000, 4'b0000, 30'h0);
    adsN = 1'b0; phaseHi = 1'b1;
    @(negedge clk);
    expectAll("R7 first", 8'h01, 1'b1, 1'b1, 1'b0);
    setStatus(3'b100, 4'b0000, 30'h8);
    @(negedge clk);
    expectAll("R9 second", 8'h08, 1'b1, 1'b0, 1'b0);
    setStatus(3'b001, 4'b0000, 30'h0);
    @(negedge clk);
    expectAll("R5 after legal", 8'h00, 1'b0, 1'b0, 1'b1);
    adsN = 1'b1; phaseHi = 1'b0;
    @(negedge clk);
    expectAll("R5 err one period", 8'h00, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic testMidReset();
    runCycle("R8 pre", 3'b110, 4'b0000, 30'h7, 8'h10, 1'b1, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    setStatus(3'b111, 4'b0000, 30'h0);
    adsN = 1'b0; phaseHi = 1'b1;
    @(negedge clk);
    expectAll("R8 mid reset", 8'h00, 1'b0, 1'b0, 1'b0);
    rst = 1'b0; adsN = 1'b1; phaseHi = 1'b0;
    @(negedge clk);
    expectAll("R8 after reset", 8'h00, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #4_000_000;
    failCount++;
    checkCount++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    testReset();
    testLegalKinds();
    testSpecial();
    testIgnored();
    testBackToBack();
    testMidReset();
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end
endmodule